// File: doc/BRIEF.md
# Three-Tap Transposed FIR Filter with Redundant Carry-Save Datapath

This block filters a stream of signed two's-complement samples with the fixed impulse response 3, 11, 27. It uses the transposed direct form. Each accepted sample is multiplied by all three coefficients in the same cycle. The products then enter a short chain of adders and delay registers, and the newest sample's product with 3 is added at the output end.

No general multiplier is used. A shared shift-and-add block forms the three products in redundant carry-save form, with each product held as a sum vector and a carry vector. The weight-3 product needs no adder: it is just the sample and the sample shifted left by one. The weight-11 product adds the sample shifted by three to that pair in one three-input carry-save adder. The weight-27 product reuses the weight-11 pair and adds the sample shifted by four in a second carry-save adder.

The additions along the delay chain also stay in carry-save form, so each delay register keeps a vector pair. Only one carry-propagate adder is used, at the output, and it resolves the final pair into a binary result. That result is registered.

Top module: `fir_cs_transposed`

## Requirements
- R1: While `rst` is high at a rising edge, the output register and all delay state clear to zero. After reset, the first output depends only on the first accepted sample, because the earlier history counts as zero.
- R2: At a rising edge with `in_valid` high, `out_result` takes the value 3·x[n] + 11·x[n−1] + 27·x[n−2]. Here x[n] is the sample accepted at that edge, and x[n−1] and x[n−2] are the two samples accepted before it. The new value is visible after that edge.
- R3: At a rising edge with `in_valid` low, `in_sample` is ignored. The output and the delay state keep their values, so the next accepted sample sees the same history.
- R4: A single nonzero sample v followed by zero samples yields the outputs 3v, 11v, 27v and then 0.
- R5: Samples are signed two's complement, `W_IN` bits wide. `out_result` is signed and `W_IN`+7 bits wide. It is exact for every input sequence, including a run of the most negative sample (41·(−2^(W_IN−1))) and a run of the most positive sample.
- R6: Each carry-save product pair from the multiplier block, with sum and carry added modulo 2^(W_IN+7), equals 3, 11 or 27 times the sign-extended current sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_sample` holds a sample to accept |
| in_sample | input | W_IN | Signed input sample |
| out_result | output | W_IN+7 | Registered signed filter output |

## Verification
The hardest case to reach is one where the redundant vectors stored in the delay registers carry long chains of carries. Only then does the final carry-propagate adder and the carry-save adder tree have to handle wrapped partial sums correctly. That takes long runs of extreme values of both signs and alternating signs, so the stimulus includes runs of the most negative and most positive samples and sign flips between them. These directed runs are mixed with seeded random samples and random idle cycles. The idle cycles occur between samples, which checks that the history kept in carry-save form survives unchanged.

// File: rtl/fir_cs_pkg.sv
package fir_cs_pkg;
    // Filter taps, newest sample first
    localparam int unsigned TAP_NEW  = 3;
    localparam int unsigned TAP_MID  = 11;
    localparam int unsigned TAP_OLD  = 27;
    // Bits of growth of the largest product and headroom for the sum of three
    localparam int unsigned PROD_GROWTH  = 5;
    localparam int unsigned ACC_HEADROOM = 2;
endpackage

// File: rtl/fir_csa3.sv
// Three-input carry-save adder (3:2 compressor) over a W-bit vector.
module fir_csa3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] out_sum,
    output logic [W-1:0] out_cy
);
    logic [W-1:0] maj;

    always_comb begin
        out_sum = in_a ^ in_b ^ in_c;
        maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        out_cy  = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/fir_cs_add4.sv
// Carry-save structural adder: two carry-save operands in, one pair out.
module fir_cs_add4 #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a_sum,
    input  logic [W-1:0] op_a_cy,
    input  logic [W-1:0] op_b_sum,
    input  logic [W-1:0] op_b_cy,
    output logic [W-1:0] res_sum,
    output logic [W-1:0] res_cy
);
    logic [W-1:0] mid_sum;
    logic [W-1:0] mid_cy;

    fir_csa3 #(.W(W)) i_stage0 (
        .in_a(op_a_sum), .in_b(op_a_cy), .in_c(op_b_sum),
        .out_sum(mid_sum), .out_cy(mid_cy)
    );

    fir_csa3 #(.W(W)) i_stage1 (
        .in_a(mid_sum), .in_b(mid_cy), .in_c(op_b_cy),
        .out_sum(res_sum), .out_cy(res_cy)
    );
endmodule

// File: rtl/fir_cs_mult_block.sv
// Shared shift-and-add block: 3x, 11x and 27x in carry-save form.
// 3x = x + 2x (no adder); 11x = 3x + 8x; 27x = 11x + 16x.
module fir_cs_mult_block #(
    parameter int W_IN = 16,
    parameter int W    = 23
) (
    input  logic signed [W_IN-1:0] smp,
    output logic [W-1:0]           m3_sum,
    output logic [W-1:0]           m3_cy,
    output logic [W-1:0]           m11_sum,
    output logic [W-1:0]           m11_cy,
    output logic [W-1:0]           m27_sum,
    output logic [W-1:0]           m27_cy
);
    localparam int N_SHIFT = 5;

    logic [W-1:0] smp_ext;
    logic [W-1:0] shifted [N_SHIFT];

    always_comb smp_ext = W'(smp);

    for (genvar k = 0; k < N_SHIFT; k++) begin : g_shift
        always_comb shifted[k] = smp_ext << k;
    end

    always_comb begin
        m3_sum = shifted[0];
        m3_cy  = shifted[1];
    end

    fir_csa3 #(.W(W)) i_csa_m11 (
        .in_a(shifted[0]), .in_b(shifted[1]), .in_c(shifted[3]),
        .out_sum(m11_sum), .out_cy(m11_cy)
    );

    fir_csa3 #(.W(W)) i_csa_m27 (
        .in_a(m11_sum), .in_b(m11_cy), .in_c(shifted[4]),
        .out_sum(m27_sum), .out_cy(m27_cy)
    );
endmodule

// File: rtl/fir_cs_transposed.sv
module fir_cs_transposed
    import fir_cs_pkg::*;
#(
    parameter int W_IN  = 16,
    parameter int W_OUT = W_IN + PROD_GROWTH + ACC_HEADROOM
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [W_IN-1:0]  in_sample,
    output logic signed [W_OUT-1:0] out_result
);
    localparam int W = W_OUT;

    typedef struct packed {
        logic [W-1:0] old_sum;   // delay holding the weight-27 term
        logic [W-1:0] old_cy;
        logic [W-1:0] mid_sum;   // delay holding weight-11 plus older terms
        logic [W-1:0] mid_cy;
        logic [W-1:0] y;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic [W-1:0] m3_sum, m3_cy, m11_sum, m11_cy, m27_sum, m27_cy;
    logic [W-1:0] mid_nx_sum, mid_nx_cy, fin_sum, fin_cy;

    fir_cs_mult_block #(.W_IN(W_IN), .W(W)) i_mult (
        .smp(in_sample),
        .m3_sum(m3_sum), .m3_cy(m3_cy),
        .m11_sum(m11_sum), .m11_cy(m11_cy),
        .m27_sum(m27_sum), .m27_cy(m27_cy)
    );

    fir_cs_add4 #(.W(W)) i_add_mid (
        .op_a_sum(m11_sum), .op_a_cy(m11_cy),
        .op_b_sum(st_q.old_sum), .op_b_cy(st_q.old_cy),
        .res_sum(mid_nx_sum), .res_cy(mid_nx_cy)
    );

    fir_cs_add4 #(.W(W)) i_add_out (
        .op_a_sum(m3_sum), .op_a_cy(m3_cy),
        .op_b_sum(st_q.mid_sum), .op_b_cy(st_q.mid_cy),
        .res_sum(fin_sum), .res_cy(fin_cy)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.old_sum = m27_sum;
            st_d.old_cy  = m27_cy;
            st_d.mid_sum = mid_nx_sum;
            st_d.mid_cy  = mid_nx_cy;
            st_d.y       = fin_sum + fin_cy;   // the single carry-propagate adder
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb out_result = st_q.y;

    // ---------------- assertions ----------------
    logic [W-1:0] smp_w;
    always_comb smp_w = W'(in_sample);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (out_result == '0 && st_q.mid_sum == '0 && st_q.mid_cy == '0
                 && st_q.old_sum == '0 && st_q.old_cy == '0));

    p_output_update_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result == W'($past(W'(3) * smp_w)
                                      + $past(st_q.mid_sum) + $past(st_q.mid_cy)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(st_q.mid_sum) && $stable(st_q.mid_cy)
                       && $stable(st_q.old_sum) && $stable(st_q.old_cy)));

    p_oldest_term_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> W'(st_q.old_sum + st_q.old_cy) == W'($past(W'(27) * smp_w)));

    p_prod3_r6: assert property (@(posedge clk) disable iff (rst)
        W'(m3_sum + m3_cy) == W'(W'(3) * smp_w));

    p_prod11_r6: assert property (@(posedge clk) disable iff (rst)
        W'(m11_sum + m11_cy) == W'(W'(11) * smp_w));

    p_prod27_r6: assert property (@(posedge clk) disable iff (rst)
        W'(m27_sum + m27_cy) == W'(W'(27) * smp_w));
endmodule

// File: tb/test_fir_cs_transposed.sv
module test_fir_cs_transposed;
    localparam int W_IN  = 16;
    localparam int W_OUT = W_IN + 7;
    localparam int SMAX  = (1 << (W_IN - 1)) - 1;
    localparam int SMIN  = -(1 << (W_IN - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W_IN-1:0]  in_sample = '0;
    logic signed [W_OUT-1:0] out_result;

    int n_checks = 0;
    int n_errors = 0;
    int hist1 = 0;
    int hist2 = 0;
    int last_y = 0;

    always #10 clk = ~clk;   // 50 MHz

    fir_cs_transposed #(.W_IN(W_IN)) i_fir_cs_transposed (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_sample(in_sample), .out_result(out_result)
    );

    function automatic int model_out(input int x, input int h1, input int h2);
        return 3 * x + 11 * h1 + 27 * h2;
    endfunction

    task automatic check(input string req, input int expv);
        n_checks++;
        if (int'(out_result) !== expv) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, int'(out_result), expv);
        end
    endtask

    // inputs change at the falling edge, results are sampled at the next one
    task automatic push(input int x, input string req);
        in_valid  = 1'b1;
        in_sample = W_IN'(x);
        @(negedge clk);
        last_y = model_out(x, hist1, hist2);
        hist2 = hist1;
        hist1 = x;
        check(req, last_y);
    endtask

    task automatic idle(input int junk, input string req);
        in_valid  = 1'b0;
        in_sample = W_IN'(junk);
        @(negedge clk);
        check(req, last_y);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hist1 = 0; hist2 = 0; last_y = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        @(negedge clk);
        do_reset();
        check("R1 reset value", 0);

        // R4 impulse response
        push(1, "R4 impulse tap0");
        push(0, "R4 impulse tap1");
        push(0, "R4 impulse tap2");
        push(0, "R4 impulse tail");
        push(-5, "R4 negative impulse tap0");
        push(0, "R4 negative impulse tap1");
        push(0, "R4 negative impulse tap2");
        push(0, "R4 negative impulse tail");

        // R2 step response
        for (int i = 0; i < 4; i++) push(7, "R2 step");

        // R3 idle cycles with toggling ignored data
        idle(12345, "R3 idle hold");
        idle(-1, "R3 idle hold");
        push(2, "R3 history kept across idle");

        // R5 extreme runs and sign flips
        for (int i = 0; i < 4; i++) push(SMIN, "R5 most negative run");
        for (int i = 0; i < 4; i++) push(SMAX, "R5 most positive run");
        for (int i = 0; i < 8; i++) push((i % 2 == 0) ? SMIN : SMAX, "R5 alternating extremes");

        // R1 mid-stream reset clears history
        do_reset();
        check("R1 reset mid stream", 0);
        push(100, "R1 first sample after reset");
        push(0, "R1 second sample after reset");

        // R2/R3/R6 seeded random mix
        for (int i = 0; i < 3000; i++) begin
            int x;
            x = int'($signed(W_IN'($urandom)));
            if (($urandom % 5) == 0) idle(x, "R3 random idle");
            else push(x, "R2 R6 random sample");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule